// File: doc/BRIEF.md
# Random Injection Pattern Inserter

This block builds an intermediate test pattern to place between two consecutive patterns of a pseudo-random generator used for on-chip self test. It compares the current pattern and the following one bit by bit. Bit positions where the two agree keep their common value. Positions where they differ are filled from a word of random bits. The changes between the two patterns are therefore split across two steps, and the sequence stays random. Each changing bit flips either on the way into the inserted pattern or on the way out of it, never on both.

A sequencer presents both patterns, a random word and a one-cycle strobe. The block returns the inserted pattern from a register, with a valid flag. The pattern source and the sequencer that orders the steps sit outside this block.

Top module: `rip_inserter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `out_pat` to all zeros and `out_valid` to 0 at that edge.
- R2: At every bit position i where `pat_cur[i]` equals `pat_next[i]`, the captured `out_pat[i]` equals that common value. `rnd_word[i]` has no effect there.
- R3: At every bit position i where `pat_cur[i]` differs from `pat_next[i]`, the captured `out_pat[i]` equals `rnd_word[i]`.
- R4: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R5: For every captured vector, Hamming(`pat_cur`, `out_pat`) + Hamming(`out_pat`, `pat_next`) equals Hamming(`pat_cur`, `pat_next`).
- R6: When `pat_next` is the bitwise complement of `pat_cur`, `out_pat` equals `rnd_word` in full. A random word equal to `pat_cur` gives the worst-case split of 0 and WIDTH transitions, and a word matching `pat_cur` in exactly half the bits gives WIDTH/2 transitions on each side.
- R7: When `pat_next` equals `pat_cur`, `out_pat` equals `pat_cur` whatever `rnd_word` holds.
- R8: A clock edge with `in_valid` low leaves `out_pat` unchanged, whatever values the data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: capture an inserted pattern at this edge |
| pat_cur | input | WIDTH | Current pattern Ti |
| pat_next | input | WIDTH | Following pattern Ti+1 |
| rnd_word | input | WIDTH | Random bits to inject at differing positions |
| out_valid | output | 1 | The inserted pattern was captured at the last edge |
| out_pat | output | WIDTH | Registered inserted pattern |

## Verification
Every result of this block is due exactly one rising edge after the strobe that carries its inputs. The bench drives the patterns, the random word and `in_valid` on a falling edge. It reads `out_pat` and `out_valid` on the next falling edge, after the single register stage has loaded. The following falling edge, with the strobe removed and the data inputs scrambled, is where the bench checks that the flag drops and the data holds. Sampling half a cycle away from the active edge means no check depends on process order at that edge.

// File: rtl/rip_pkg.sv
package rip_pkg;

    // Default width of the pattern path.
    localparam int unsigned RIP_WIDTH_DEF = 20;

    // Which source a single output bit is taken from.
    typedef enum logic {
        SRC_KEEP = 1'b0,
        SRC_RAND = 1'b1
    } rip_src_e;

    // Decide the source for one bit from the two pattern bits.
    function automatic rip_src_e pick_src(input logic cur_b, input logic nxt_b);
        return (cur_b ^ nxt_b) ? SRC_RAND : SRC_KEEP;
    endfunction

endpackage

// File: rtl/rip_diff_mask.sv
module rip_diff_mask #(
    parameter int unsigned WIDTH = rip_pkg::RIP_WIDTH_DEF
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] nxt_i,
    output logic [WIDTH-1:0] diff_o
);
    import rip_pkg::*;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        rip_src_e src;
        assign src       = pick_src(cur_i[g], nxt_i[g]);
        assign diff_o[g] = (src == SRC_RAND);
    end

endmodule

// File: rtl/rip_bit_sel.sv
module rip_bit_sel #(
    parameter int unsigned WIDTH = rip_pkg::RIP_WIDTH_DEF
) (
    input  logic [WIDTH-1:0] keep_i,
    input  logic [WIDTH-1:0] rnd_i,
    input  logic [WIDTH-1:0] diff_i,
    output logic [WIDTH-1:0] sel_o
);
    import rip_pkg::*;

    // One two-input multiplexer per bit position.
    for (genvar g = 0; g < WIDTH; g++) begin : g_mux
        rip_src_e src;
        assign src = diff_i[g] ? SRC_RAND : SRC_KEEP;
        always_comb begin
            unique case (src)
                SRC_RAND: sel_o[g] = rnd_i[g];
                default:  sel_o[g] = keep_i[g];
            endcase
        end
    end

endmodule

// File: rtl/rip_out_stage.sv
module rip_out_stage #(
    parameter int unsigned WIDTH = rip_pkg::RIP_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic             vld_o,
    output logic [WIDTH-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            q_o   <= '0;
        end else begin
            vld_o <= load_i;
            if (load_i) begin
                q_o <= d_i;
            end
        end
    end

    // R4: flag follows the strobe by one edge
    p_valid_lat_r4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> vld_o);
    p_valid_drop_r4: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> !vld_o);
    // R8: no load, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_o));
    // R1: reset clears the stage
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!vld_o && q_o == '0));

endmodule

// File: rtl/rip_inserter.sv
module rip_inserter #(
    parameter int unsigned WIDTH = rip_pkg::RIP_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] pat_cur,
    input  logic [WIDTH-1:0] pat_next,
    input  logic [WIDTH-1:0] rnd_word,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_pat
);

    logic [WIDTH-1:0] diff_w;
    logic [WIDTH-1:0] ins_w;

    rip_diff_mask #(.WIDTH(WIDTH)) u_diff (
        .cur_i  (pat_cur),
        .nxt_i  (pat_next),
        .diff_o (diff_w)
    );

    rip_bit_sel #(.WIDTH(WIDTH)) u_sel (
        .keep_i (pat_cur),
        .rnd_i  (rnd_word),
        .diff_i (diff_w),
        .sel_o  (ins_w)
    );

    rip_out_stage #(.WIDTH(WIDTH)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .load_i (in_valid),
        .d_i    (ins_w),
        .vld_o  (out_valid),
        .q_o    (out_pat)
    );

    // R2: agreeing positions keep the common value
    p_agree_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (((out_pat ^ $past(pat_cur)) & ~($past(pat_cur) ^ $past(pat_next))) == '0));
    // R3: differing positions carry the random bit
    p_inject_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (((out_pat ^ $past(rnd_word)) & ($past(pat_cur) ^ $past(pat_next))) == '0));
    // R5: transitions are split, never added
    p_split_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ($countones(out_pat ^ $past(pat_cur)) + $countones(out_pat ^ $past(pat_next))
                      == $countones($past(pat_cur) ^ $past(pat_next))));

endmodule

// File: tb/rip_inserter_tb.sv
module rip_inserter_tb;
    localparam int unsigned W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] pat_cur = '0;
    logic [W-1:0] pat_next = '0;
    logic [W-1:0] rnd_word = '0;
    logic         out_valid;
    logic [W-1:0] out_pat;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rip_inserter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .pat_cur(pat_cur), .pat_next(pat_next), .rnd_word(rnd_word),
        .out_valid(out_valid), .out_pat(out_pat)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] r);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = (a[i] == b[i]) ? a[i] : r[i];
        return m;
    endfunction

    // Present one vector, read the result one edge later, then drop the strobe.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] r, output logic [W-1:0] got);
        @(negedge clk);
        pat_cur = a; pat_next = b; rnd_word = r; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got = out_pat;
        check(out_valid == 1'b1, "R4 valid after strobe", {{(W-1){1'b0}}, out_valid}, 1);
        check(got == model(a, b, r), "R2/R3 inserted value", got, model(a, b, r));
        check($countones(got ^ a) + $countones(got ^ b) == $countones(a ^ b),
              "R5 hamming split", got, model(a, b, r));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", {{(W-1){1'b0}}, out_valid}, 0);
        check(out_pat == '0, "R1 pattern in reset", out_pat, '0);
        rst = 1'b0;
    endtask

    task automatic t_identical();
        logic [W-1:0] got;
        apply(20'hA5C3F, 20'hA5C3F, 20'h5A3C0, got);
        check(got == 20'hA5C3F, "R7 identical patterns", got, 20'hA5C3F);
        apply(20'h00000, 20'h00000, 20'hFFFFF, got);
        check(got == 20'h00000, "R7 identical zeros", got, 20'h00000);
    endtask

    task automatic t_complement();
        logic [W-1:0] got;
        apply(20'h3C5A1, ~20'h3C5A1, 20'h3C5A1, got);
        check(got == 20'h3C5A1, "R6 worst split rnd=cur", got, 20'h3C5A1);
        check($countones(got ^ 20'h3C5A1) == 0, "R6 zero first step", got, 20'h3C5A1);
        apply(20'h00000, 20'hFFFFF, 20'h003FF, got);
        check(got == 20'h003FF, "R6 best split", got, 20'h003FF);
        check($countones(got) == W / 2, "R6 half transitions", got, 20'h003FF);
    endtask

    task automatic t_mixed();
        logic [W-1:0] got;
        logic [W-1:0] a, b, r;
        for (int k = 0; k < 40; k++) begin
            a = W'($urandom); b = W'($urandom); r = W'($urandom);
            apply(a, b, r, got);
        end
        apply(20'hF0F0F, 20'hF0FF0, 20'h0000F, got);
        check(got == 20'hF0F0F, "R2 agree bits kept, R3 rnd low nibble", got, 20'hF0F0F);
    endtask

    task automatic t_hold();
        logic [W-1:0] got;
        logic [W-1:0] prev;
        apply(20'h12345, 20'h6789A, 20'hBCDEF, got);
        prev = out_pat;
        pat_cur = 20'hFFFFF; pat_next = 20'h00000; rnd_word = 20'h55555;
        @(negedge clk);
        check(out_valid == 1'b0, "R4 valid drops", {{(W-1){1'b0}}, out_valid}, 0);
        check(out_pat == prev, "R8 hold without strobe", out_pat, prev);
        @(negedge clk);
        check(out_pat == prev, "R8 hold second cycle", out_pat, prev);
    endtask

    initial begin
        t_reset();
        t_identical();
        t_complement();
        t_mixed();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule